// File: doc/BRIEF.md
# Dual-Channel DMA Request Router

This block sits between a handful of peripheral request lines and two DMA channels. It decides which request each channel sees. Channel 0 always draws on external request 0. Channel 1 draws on a source picked by a three-bit code in the control register, together with a direction input that chooses between the serial ports' transmit and receive requests.

A steering flag in the control register lets both channels serve the same device in turn. While the flag is low, external request 0 reaches channel 0 only. While it is high, external request 0 reaches channel 1 only, and channel 0 sees nothing. When alternation is enabled, the flag moves by itself. A terminal-count pulse from channel 0 hands the device to channel 1, and one from channel 1 hands it back. Software can also write the flag directly.

The register is written through a one-cycle write strobe and read back combinationally. The routed request outputs are combinational from the stored flag, the source code and the raw request inputs.

Top module: `dma_req_router`

## Requirements
- R1: After reset, `reg_rd_data` reads 8'h00. Alternation is off, the flag is 0 and the source code is 0.
- R2: A write stores bit 7 (alternate enable), bit 6 (steering flag) and bits 2:0 (channel-1 source code). Read-back returns those bits in the same positions, and bits 5:3 always read 0 whatever was written.
- R3: With alternate enable set and no write in that cycle, a `tc0` pulse without `tc1` sets the flag on the next clock edge.
- R4: With alternate enable set and no write in that cycle, a `tc1` pulse without `tc0` clears the flag on the next clock edge.
- R5: With alternate enable set and no write in that cycle, `tc0` and `tc1` together invert the flag.
- R6: With alternate enable clear, terminal-count pulses leave the register unchanged.
- R7: A register write in the same cycle as a terminal-count pulse wins. The flag takes the written bit 6.
- R8: While the flag is 0, `ch0_req` follows `ext_req0`.
- R9: While the flag is 0 and `ch1_mode_rx` is 0, source codes 0, 1 and 2 route `ext_req1`, `ser_tx_req[0]` and `ser_tx_req[1]` to `ch1_req`.
- R10: While the flag is 0 and `ch1_mode_rx` is 1, source codes 0, 1 and 2 route `ext_req1`, `ser_rx_req[0]` and `ser_rx_req[1]` to `ch1_req`.
- R11: While the flag is 0, `ch1_req` is 0 for two kinds of code. The first is code 3, which selects `ext_req0`, so that request is held for channel 0. The second is the reserved codes 4 to 7.
- R12: While the flag is 1, `ch0_req` is 0 and `ch1_req` follows `ext_req0`, whatever the source code and direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| reg_rd_data | output | 8 | Control register read-back |
| ch1_mode_rx | input | 1 | Channel-1 direction: 0 selects serial transmit requests, 1 selects receive |
| ext_req0 | input | 1 | External request 0, the shared device request |
| ext_req1 | input | 1 | External request 1 |
| ser_tx_req | input | 2 | Serial port transmit requests, one per port |
| ser_rx_req | input | 2 | Serial port receive requests, one per port |
| tc0 | input | 1 | Channel 0 terminal-count pulse |
| tc1 | input | 1 | Channel 1 terminal-count pulse |
| ch0_req | output | 1 | Request presented to channel 0 |
| ch1_req | output | 1 | Request presented to channel 1 |

## Verification
The flag is the only state that changes without software acting. If it ends up wrong after a terminal-count pulse, two things show it on the following cycle. The read-back shows the wrong bit 6. The two request outputs also swap which one follows `ext_req0`. A wrong source code shows up on `ch1_req` as soon as the selected request line differs from the one actually routed. For that reason the bench sweeps every code, both directions, both flag values and all 64 request-input patterns, and it reads the register back after every terminal-count and write case.

// File: rtl/dmarr_pkg.sv
package dmarr_pkg;
  localparam int CTRL_W   = 8;
  localparam int SEL_W    = 3;
  localparam int NUM_SER  = 2;
  localparam int ALT_BIT  = 7;
  localparam int FLAG_BIT = 6;
  // Code of the channel-0 request inside channel 1's source list
  localparam int CODE_SHARED = NUM_SER + 1;
  localparam int NUM_CODES   = NUM_SER + 2;

  typedef struct packed {
    logic             alt_en;
    logic             sel_ch1;
    logic [SEL_W-1:0] src;
  } ctrl_t;
endpackage

// File: rtl/dmarr_rst_sync.sv
module dmarr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dmarr_ctrl_reg.sv
module dmarr_ctrl_reg
  import dmarr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              tc0,
  input  logic              tc1,
  output ctrl_t             ctrl_q,
  output logic [CTRL_W-1:0] rd_data
);
  ctrl_t ctrl_d;
  logic  upd_en;

  // Next state: a write overrides any terminal-count update
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.alt_en  = wr_data[ALT_BIT];
      ctrl_d.sel_ch1 = wr_data[FLAG_BIT];
      ctrl_d.src     = wr_data[SEL_W-1:0];
    end else if (ctrl_q.alt_en) begin
      unique case ({tc1, tc0})
        2'b01:   ctrl_d.sel_ch1 = 1'b1;
        2'b10:   ctrl_d.sel_ch1 = 1'b0;
        2'b11:   ctrl_d.sel_ch1 = ~ctrl_q.sel_ch1;
        default: ctrl_d.sel_ch1 = ctrl_q.sel_ch1;
      endcase
    end
  end

  assign upd_en = wr_en | (ctrl_q.alt_en & (tc0 | tc1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (upd_en) ctrl_q <= ctrl_d;
  end

  always_comb begin
    rd_data                = '0;
    rd_data[ALT_BIT]       = ctrl_q.alt_en;
    rd_data[FLAG_BIT]      = ctrl_q.sel_ch1;
    rd_data[SEL_W-1:0]     = ctrl_q.src;
  end

  // R3
  tc0_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctrl_q.alt_en && tc0 && !tc1) |=> ctrl_q.sel_ch1);
  // R4
  tc1_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctrl_q.alt_en && !tc0 && tc1) |=> !ctrl_q.sel_ch1);
  // R5
  both_tc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctrl_q.alt_en && tc0 && tc1) |=> (ctrl_q.sel_ch1 != $past(ctrl_q.sel_ch1)));
  // R6
  no_alt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ctrl_q.alt_en) |=> $stable(rd_data));
  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q.sel_ch1 == $past(wr_data[FLAG_BIT])));
endmodule

// File: rtl/dmarr_src_mux.sv
module dmarr_src_mux
  import dmarr_pkg::*;
(
  input  logic [SEL_W-1:0]   code,
  input  logic               mode_rx,
  input  logic               ext_req0,
  input  logic               ext_req1,
  input  logic [NUM_SER-1:0] ser_tx,
  input  logic [NUM_SER-1:0] ser_rx,
  output logic               routed,
  output logic               shared
);
  logic [NUM_CODES-1:0] cand;

  assign cand[0]           = ext_req1;
  assign cand[CODE_SHARED] = ext_req0;

  for (genvar g = 0; g < NUM_SER; g++) begin : g_ser
    assign cand[g+1] = mode_rx ? ser_rx[g] : ser_tx[g];
  end

  // Codes past the candidate list are reserved and route nothing
  always_comb begin
    routed = 1'b0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (code == SEL_W'(i)) routed = cand[i];
    end
  end

  assign shared = (code == SEL_W'(CODE_SHARED));
endmodule

// File: rtl/dmarr_gate.sv
module dmarr_gate (
  input  logic sel_ch1,
  input  logic ext_req0,
  input  logic routed,
  input  logic shared,
  output logic ch0_req,
  output logic ch1_req
);
  always_comb begin
    if (sel_ch1) begin
      ch0_req = 1'b0;
      ch1_req = ext_req0;
    end else begin
      ch0_req = ext_req0;
      ch1_req = routed & ~shared;
    end
  end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmarr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [CTRL_W-1:0] reg_wr_data,
  output logic [CTRL_W-1:0] reg_rd_data,
  input  logic              ch1_mode_rx,
  input  logic              ext_req0,
  input  logic              ext_req1,
  input  logic [NUM_SER-1:0] ser_tx_req,
  input  logic [NUM_SER-1:0] ser_rx_req,
  input  logic              tc0,
  input  logic              tc1,
  output logic              ch0_req,
  output logic              ch1_req
);
  logic  rst_sync_n;
  ctrl_t ctrl_q;
  logic  routed;
  logic  shared;

  dmarr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dmarr_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .tc0     (tc0),
    .tc1     (tc1),
    .ctrl_q  (ctrl_q),
    .rd_data (reg_rd_data)
  );

  dmarr_src_mux u_mux (
    .code     (ctrl_q.src),
    .mode_rx  (ch1_mode_rx),
    .ext_req0 (ext_req0),
    .ext_req1 (ext_req1),
    .ser_tx   (ser_tx_req),
    .ser_rx   (ser_rx_req),
    .routed   (routed),
    .shared   (shared)
  );

  dmarr_gate u_gate (
    .sel_ch1  (ctrl_q.sel_ch1),
    .ext_req0 (ext_req0),
    .routed   (routed),
    .shared   (shared),
    .ch0_req  (ch0_req),
    .ch1_req  (ch1_req)
  );

  // R12
  steered_ch0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_q.sel_ch1 |-> (!ch0_req && (ch1_req == ext_req0)));
  // R8
  ch0_follows_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_q.sel_ch1 |-> (ch0_req == ext_req0));
  // R11
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_q.sel_ch1 && (ctrl_q.src >= SEL_W'(CODE_SHARED))) |-> !ch1_req);
endmodule

// File: tb/dma_req_router_tb.sv
`timescale 1ns/1ps
module dma_req_router_tb;
  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en;
  logic [7:0] reg_wr_data;
  logic [7:0] reg_rd_data;
  logic       ch1_mode_rx;
  logic       ext_req0, ext_req1;
  logic [1:0] ser_tx_req, ser_rx_req;
  logic       tc0, tc1;
  logic       ch0_req, ch1_req;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(HALF) clk = ~clk;

  dma_req_router u_dut (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
    .ch1_mode_rx (ch1_mode_rx), .ext_req0 (ext_req0), .ext_req1 (ext_req1),
    .ser_tx_req (ser_tx_req), .ser_rx_req (ser_rx_req),
    .tc0 (tc0), .tc1 (tc1), .ch0_req (ch0_req), .ch1_req (ch1_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle of write and/or terminal count, then read back
  task automatic cycle(input logic we, input logic [7:0] d, input logic t0, input logic t1,
                       input string req, input logic [7:0] exp);
    @(negedge clk);
    reg_wr_en = we; reg_wr_data = d; tc0 = t0; tc1 = t1;
    @(negedge clk);
    reg_wr_en = 1'b0; tc0 = 1'b0; tc1 = 1'b0;
    #1;
    check(req, reg_rd_data, exp);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_data = '0; ch1_mode_rx = 1'b0;
    ext_req0 = 1'b0; ext_req1 = 1'b0; ser_tx_req = '0; ser_rx_req = '0;
    tc0 = 1'b0; tc1 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset", reg_rd_data, 8'h00);

    // R2: every write value, bits 5:3 masked on read-back
    for (int d = 0; d < 256; d++) begin
      cycle(1'b1, 8'(d), 1'b0, 1'b0, "R2 write/read", 8'(d) & 8'hC7);
    end

    // R3 / R4 / R5 with alternation enabled
    cycle(1'b1, 8'h80, 1'b0, 1'b0, "R2 setup", 8'h80);
    cycle(1'b0, 8'h00, 1'b1, 1'b0, "R3 tc0 sets", 8'hC0);
    cycle(1'b0, 8'h00, 1'b1, 1'b0, "R3 tc0 holds set", 8'hC0);
    cycle(1'b0, 8'h00, 1'b0, 1'b1, "R4 tc1 clears", 8'h80);
    cycle(1'b0, 8'h00, 1'b0, 1'b1, "R4 tc1 holds clear", 8'h80);
    cycle(1'b0, 8'h00, 1'b1, 1'b1, "R5 both toggle up", 8'hC0);
    cycle(1'b0, 8'h00, 1'b1, 1'b1, "R5 both toggle down", 8'h80);
    // R6: alternation off
    cycle(1'b1, 8'h03, 1'b0, 1'b0, "R2 setup", 8'h03);
    cycle(1'b0, 8'h00, 1'b1, 1'b0, "R6 tc0 ignored", 8'h03);
    cycle(1'b0, 8'h00, 1'b1, 1'b1, "R6 both ignored", 8'h03);
    cycle(1'b1, 8'h42, 1'b0, 1'b0, "R2 setup", 8'h42);
    cycle(1'b0, 8'h00, 1'b0, 1'b1, "R6 tc1 ignored", 8'h42);
    // R7: write beats terminal count
    cycle(1'b1, 8'hC1, 1'b0, 1'b0, "R2 setup", 8'hC1);
    cycle(1'b1, 8'h81, 1'b1, 1'b0, "R7 write vs tc0", 8'h81);
    cycle(1'b1, 8'hC1, 1'b0, 1'b1, "R7 write vs tc1", 8'hC1);
    cycle(1'b1, 8'h81, 1'b1, 1'b1, "R7 write vs both", 8'h81);

    // R8..R12: full routing sweep
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 8; c++) begin
        cycle(1'b1, 8'((f << 6) | c), 1'b0, 1'b0, "R2 setup", 8'((f << 6) | c));
        for (int m = 0; m < 2; m++) begin
          for (int p = 0; p < 64; p++) begin
            logic e0, e1, exp0, exp1;
            logic [1:0] tx, rx, ser;
            string rq;
            @(negedge clk);
            e0 = p[0]; e1 = p[1]; tx = 2'(p >> 2); rx = 2'(p >> 4);
            ch1_mode_rx = m[0]; ext_req0 = e0; ext_req1 = e1;
            ser_tx_req = tx; ser_rx_req = rx;
            ser = m[0] ? rx : tx;
            if (f == 1) begin
              exp0 = 1'b0; exp1 = e0; rq = "R12";
            end else begin
              exp0 = e0;
              if (c == 0) begin exp1 = e1; rq = m[0] ? "R10" : "R9"; end
              else if (c <= 2) begin exp1 = ser[c-1]; rq = m[0] ? "R10" : "R9"; end
              else begin exp1 = 1'b0; rq = "R11"; end
            end
            #1;
            check(f == 1 ? "R12 ch0" : "R8 ch0", {7'b0, ch0_req}, {7'b0, exp0});
            check({rq, " ch1"}, {7'b0, ch1_req}, {7'b0, exp1});
          end
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule